// File: doc/BRIEF.md
# Base-16 Floating-Point Normalized Adder (Short Format)

This block adds two 32-bit floating-point words whose exponent counts powers of sixteen. Both operands are aligned by shifting whole hex digits, their fractions are combined as signed magnitudes with one guard digit, a carry is absorbed by a one-digit right shift, and the sum is post-normalized by left shifts of whole hex digits. The result is truncated, with no rounding.

A caller presents both operands together with a one-cycle `start` strobe. One clock later the block raises `done` for one cycle. On that cycle it presents the registered sum, a two-bit condition code and three exception flags. Outputs keep their values until the next strobe. Masking and delivery of the exception conditions belong to the surrounding logic.

Top module: `hfp_add_short`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared to zero: `done`, `sum_out`, `cc` and the three flags.
- R2: A `start` sampled high at a clock edge makes `done` high for exactly the following cycle, with results valid on that cycle. Without `start`, `done` is low and every result output holds its previous value.
- R3: Word layout. Bit 31 is the sign (1 = negative). Bits 30:24 hold a 7-bit exponent, biased by 64, that counts powers of 16. Bits 23:0 hold six hex fraction digits, with the most significant digit in bits 23:20. Two same-sign operands with equal exponents add their fractions directly.
- R4: The operand with the smaller exponent has its fraction moved right by one hex digit for each unit of exponent difference. This works whichever input holds the smaller exponent. A difference of seven or more digits makes that operand contribute zero.
- R5: Exactly one guard digit, the first digit shifted out during alignment, takes part in the addition. It enters the fraction first on post-normalization. Example: 0x41100000 + 0xC0FFFFFF = 0x3B100000.
- R6: If a same-sign magnitude addition carries out, the sum moves right by one hex digit and the exponent rises by one. Example: 0x41800000 + 0x41800000 = 0x42100000.
- R7: For opposite signs, the smaller aligned magnitude is subtracted from the larger one, and the result takes the sign of the larger one.
- R8: A nonzero sum is shifted left one hex digit at a time until bits 23:20 are nonzero, and the exponent drops by one per digit. The guard digit is then dropped with no rounding.
- R9: If the carry increment pushes the exponent past 127, `exp_ovf` is set and `cc` = 3. The exponent field holds the value modulo 128, and the sign and fraction are kept.
- R10: If normalization drives the exponent below zero on a nonzero sum, `exp_unf` is set, `sum_out` is all zeros and `cc` = 0.
- R11: If the summed fraction is zero, `signif` is set, `sum_out` is all zeros (positive, exponent zero) and `cc` = 0.
- R12: Otherwise `cc` is 1 for a negative result and 2 for a positive result. At most one of the three flags is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operands sampled with it |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| done | output | 1 | One-cycle pulse marking valid results |
| sum_out | output | 32 | Normalized sum |
| cc | output | 2 | Condition code: 0 zero, 1 negative, 2 positive, 3 overflow |
| exp_ovf | output | 1 | Exponent overflow on carry |
| exp_unf | output | 1 | Exponent underflow on normalization |
| signif | output | 1 | Zero fraction sum |

## Verification
Every result (sum, condition code, flags and `done`) is registered once at the edge that samples `start`, so all of them are due exactly one cycle after the strobe. The bench drives the strobe on a falling edge. It reads all outputs at the next falling edge, after the single capturing rising edge. It then drops `start` and reads again one cycle later to confirm that `done` has fallen and the results have held. The chosen operand pairs separate guard-digit use, carry, sign choice, deep alignment and each exception path, and their expected words are worked out by hand from the requirements.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int DIG_W = 4;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_NEG  = 2'd1,
    CC_POS  = 2'd2,
    CC_OVF  = 2'd3
  } hfp_cc_e;
endpackage

// File: rtl/hfp_align.sv
module hfp_align
  import hfp_pkg::*;
#(
  parameter int EXP_W    = 7,
  parameter int FRAC_DIG = 6,
  localparam int FW      = FRAC_DIG * DIG_W,
  localparam int MW      = FW + DIG_W
) (
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [FW-1:0]    a_frac,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [FW-1:0]    b_frac,
  output logic             big_sign,
  output logic             small_sign,
  output logic [MW-1:0]    big_mag,
  output logic [MW-1:0]    small_mag,
  output logic [EXP_W-1:0] base_exp
);
  logic             a_wins;
  logic [EXP_W-1:0] gap;
  logic [MW-1:0]    small_ext;

  always_comb begin
    a_wins     = (a_exp >= b_exp);
    gap        = a_wins ? (a_exp - b_exp) : (b_exp - a_exp);
    base_exp   = a_wins ? a_exp : b_exp;
    big_sign   = a_wins ? a_sign : b_sign;
    small_sign = a_wins ? b_sign : a_sign;
    big_mag    = a_wins ? {a_frac, {DIG_W{1'b0}}} : {b_frac, {DIG_W{1'b0}}};
    small_ext  = a_wins ? {b_frac, {DIG_W{1'b0}}} : {a_frac, {DIG_W{1'b0}}};
    if (gap > EXP_W'(FRAC_DIG))
      small_mag = '0;
    else
      small_mag = small_ext >> ({gap, 2'b00});
  end
endmodule

// File: rtl/hfp_addsub.sv
module hfp_addsub #(
  parameter int MW = 28
) (
  input  logic          big_sign,
  input  logic          small_sign,
  input  logic [MW-1:0] big_mag,
  input  logic [MW-1:0] small_mag,
  output logic [MW:0]   sum_mag,
  output logic          sum_sign
);
  logic same_sign;
  logic big_ge;

  always_comb begin
    same_sign = (big_sign == small_sign);
    big_ge    = (big_mag >= small_mag);
    if (same_sign) begin
      sum_mag  = {1'b0, big_mag} + {1'b0, small_mag};
      sum_sign = big_sign;
    end else if (big_ge) begin
      sum_mag  = {1'b0, big_mag} - {1'b0, small_mag};
      sum_sign = big_sign;
    end else begin
      sum_mag  = {1'b0, small_mag} - {1'b0, big_mag};
      sum_sign = small_sign;
    end
  end
endmodule

// File: rtl/hfp_norm.sv
module hfp_norm
  import hfp_pkg::*;
#(
  parameter int EXP_W    = 7,
  parameter int FRAC_DIG = 6,
  localparam int FW      = FRAC_DIG * DIG_W,
  localparam int MW      = FW + DIG_W,
  localparam int DIGS    = FRAC_DIG + 1,
  localparam int SW      = EXP_W + 2,
  localparam int WW      = 1 + EXP_W + FW
) (
  input  logic [MW:0]      sum_mag,
  input  logic             sum_sign,
  input  logic [EXP_W-1:0] base_exp,
  output logic [WW-1:0]    res_word,
  output logic [1:0]       res_cc,
  output logic             res_ovf,
  output logic             res_unf,
  output logic             res_sig
);
  localparam logic signed [SW-1:0] EXP_MAX = SW'((1 << EXP_W) - 1);

  logic                 carry;
  logic [MW-1:0]        mid;
  logic [MW-1:0]        shifted;
  logic signed [SW-1:0] exp_mid;
  logic signed [SW-1:0] exp_fin;
  logic [SW-1:0]        lead_zeros;
  logic                 seen;
  logic                 mid_zero;

  always_comb begin
    carry   = sum_mag[MW];
    mid     = carry ? {{(DIG_W-1){1'b0}}, sum_mag[MW:DIG_W]} : sum_mag[MW-1:0];
    exp_mid = $signed({2'b00, base_exp}) + $signed(SW'(carry));

    lead_zeros = '0;
    seen       = 1'b0;
    for (int d = DIGS - 1; d >= 0; d--) begin
      if (!seen) begin
        if (mid[d*DIG_W +: DIG_W] != '0) seen = 1'b1;
        else lead_zeros = lead_zeros + 1'b1;
      end
    end

    mid_zero = (mid == '0);
    shifted  = mid << (lead_zeros * DIG_W);
    exp_fin  = exp_mid - $signed(lead_zeros);

    res_ovf = carry && (exp_mid > EXP_MAX);
    res_sig = mid_zero;
    res_unf = !mid_zero && (exp_fin < 0);

    if (mid_zero || res_unf) begin
      res_word = '0;
      res_cc   = CC_ZERO;
    end else begin
      res_word = {sum_sign, exp_fin[EXP_W-1:0], shifted[MW-1:DIG_W]};
      if (res_ovf)       res_cc = CC_OVF;
      else if (sum_sign) res_cc = CC_NEG;
      else               res_cc = CC_POS;
    end
  end
endmodule

// File: rtl/hfp_add_short.sv
module hfp_add_short
  import hfp_pkg::*;
#(
  parameter int EXP_W    = 7,
  parameter int FRAC_DIG = 6,
  localparam int FW      = FRAC_DIG * DIG_W,
  localparam int MW      = FW + DIG_W,
  localparam int WW      = 1 + EXP_W + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [WW-1:0] opnd_a,
  input  logic [WW-1:0] opnd_b,
  output logic          done,
  output logic [WW-1:0] sum_out,
  output logic [1:0]    cc,
  output logic          exp_ovf,
  output logic          exp_unf,
  output logic          signif
);
  logic             big_sign, small_sign, sum_sign;
  logic [MW-1:0]    big_mag, small_mag;
  logic [MW:0]      sum_mag;
  logic [EXP_W-1:0] base_exp;
  logic [WW-1:0]    n_word;
  logic [1:0]       n_cc;
  logic             n_ovf, n_unf, n_sig;

  hfp_align #(.EXP_W(EXP_W), .FRAC_DIG(FRAC_DIG)) u_align (
    .a_sign    (opnd_a[WW-1]),
    .a_exp     (opnd_a[WW-2 -: EXP_W]),
    .a_frac    (opnd_a[FW-1:0]),
    .b_sign    (opnd_b[WW-1]),
    .b_exp     (opnd_b[WW-2 -: EXP_W]),
    .b_frac    (opnd_b[FW-1:0]),
    .big_sign  (big_sign),
    .small_sign(small_sign),
    .big_mag   (big_mag),
    .small_mag (small_mag),
    .base_exp  (base_exp)
  );

  hfp_addsub #(.MW(MW)) u_addsub (
    .big_sign  (big_sign),
    .small_sign(small_sign),
    .big_mag   (big_mag),
    .small_mag (small_mag),
    .sum_mag   (sum_mag),
    .sum_sign  (sum_sign)
  );

  hfp_norm #(.EXP_W(EXP_W), .FRAC_DIG(FRAC_DIG)) u_norm (
    .sum_mag (sum_mag),
    .sum_sign(sum_sign),
    .base_exp(base_exp),
    .res_word(n_word),
    .res_cc  (n_cc),
    .res_ovf (n_ovf),
    .res_unf (n_unf),
    .res_sig (n_sig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      sum_out <= '0;
      cc      <= CC_ZERO;
      exp_ovf <= 1'b0;
      exp_unf <= 1'b0;
      signif  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        sum_out <= n_word;
        cc      <= n_cc;
        exp_ovf <= n_ovf;
        exp_unf <= n_unf;
        signif  <= n_sig;
      end
    end
  end

  // R2: done timing and result hold
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  a_r2_result_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(sum_out) && $stable(cc)));
  // R8: a reported nonzero result has a nonzero leading digit
  a_r8_normalized: assert property (@(posedge clk) disable iff (rst)
    (done && !signif && !exp_unf) |-> (sum_out[FW-1 -: DIG_W] != '0));
  // R9: overflow reports code 3
  a_r9_ovf_code: assert property (@(posedge clk) disable iff (rst)
    exp_ovf |-> (cc == CC_OVF));
  // R10: underflow forces a true zero
  a_r10_unf_zero: assert property (@(posedge clk) disable iff (rst)
    exp_unf |-> (sum_out == '0 && cc == CC_ZERO));
  // R11: zero fraction gives positive zero
  a_r11_sig_zero: assert property (@(posedge clk) disable iff (rst)
    signif |-> (sum_out == '0 && cc == CC_ZERO));
  // R12: flags mutually exclusive
  a_r12_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exp_ovf, exp_unf, signif}));
endmodule

// File: tb/hfp_add_short_bench.sv
module hfp_add_short_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] opnd_a, opnd_b;
  logic        done;
  logic [31:0] sum_out;
  logic [1:0]  cc;
  logic        exp_ovf, exp_unf, signif;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hfp_add_short u_hfp_add_short (
    .clk(clk), .rst(rst), .start(start),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .done(done), .sum_out(sum_out), .cc(cc),
    .exp_ovf(exp_ovf), .exp_unf(exp_unf), .signif(signif)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // flags expected as {ovf, unf, sig}
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp_sum, input logic [1:0] exp_cc,
                        input logic [2:0] exp_flags);
    @(negedge clk);
    opnd_a = a; opnd_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, "done", {31'b0, done}, 32'd1);
    check(req, "sum", sum_out, exp_sum);
    check(req, "cc", {30'b0, cc}, {30'b0, exp_cc});
    check(req, "flags", {29'b0, exp_ovf, exp_unf, signif}, {29'b0, exp_flags});
    opnd_a = 32'h5A5A5A5A; opnd_b = 32'hA5A5A5A5;
    @(negedge clk);
    check("R2", "done falls", {31'b0, done}, 32'd0);
    check("R2", "sum holds", sum_out, exp_sum);
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R1", "done", {31'b0, done}, 32'd0);
    check("R1", "sum", sum_out, 32'd0);
    check("R1", "cc+flags", {27'b0, cc, exp_ovf, exp_unf, signif}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic test_equal_exp();
    run_op("R3", 32'h41200000, 32'h41300000, 32'h41500000, 2'd2, 3'b000);
    run_op("R12", 32'hC1200000, 32'hC1300000, 32'hC1500000, 2'd1, 3'b000);
  endtask

  task automatic test_align();
    run_op("R4", 32'h42123456, 32'h41ABCDEF, 32'h421CF134, 2'd2, 3'b000);
    run_op("R4", 32'h41ABCDEF, 32'h42123456, 32'h421CF134, 2'd2, 3'b000);
    run_op("R4", 32'h48100000, 32'h40FFFFFF, 32'h48100000, 2'd2, 3'b000);
    run_op("R4", 32'h40FFFFFF, 32'h47100000, 32'h47100000, 2'd2, 3'b000);
  endtask

  task automatic test_guard();
    run_op("R5", 32'h41100000, 32'hC0FFFFFF, 32'h3B100000, 2'd2, 3'b000);
  endtask

  task automatic test_carry();
    run_op("R6", 32'h41800000, 32'h41800000, 32'h42100000, 2'd2, 3'b000);
  endtask

  task automatic test_signs();
    run_op("R7", 32'h41200000, 32'hC1500000, 32'hC1300000, 2'd1, 3'b000);
  endtask

  task automatic test_normalize();
    run_op("R8", 32'h42000100, 32'h42000000, 32'h3F100000, 2'd2, 3'b000);
  endtask

  task automatic test_overflow();
    run_op("R9", 32'h7F800000, 32'h7F800000, 32'h00100000, 2'd3, 3'b100);
  endtask

  task automatic test_underflow();
    run_op("R10", 32'h00100000, 32'h80080000, 32'h00000000, 2'd0, 3'b010);
  endtask

  task automatic test_signif();
    run_op("R11", 32'h41500000, 32'hC1500000, 32'h00000000, 2'd0, 3'b001);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_equal_exp();
    test_align();
    test_guard();
    test_carry();
    test_signs();
    test_normalize();
    test_overflow();
    test_underflow();
    test_signif();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule